// File: doc/BRIEF.md
# Crystal Oscillator Enable and Start-Up Controller

This block owns the byte-wide control register of an external high-frequency oscillator and turns its settings into the signals the oscillator and the clock system need. It decides when the oscillator runs. In on-demand mode the oscillator runs only while a peripheral or the main clock asks for it. In always-on mode it runs in every sleep mode except the deepest one. Each time the oscillator starts, the block counts a selectable number of oscillator cycles before it raises a stable flag.

Oscillator cycles arrive as a one-cycle tick pulse in the system clock domain. After start-up has finished, a requesting client gets a clock-available indication once two more oscillator ticks have passed. The register is guarded: a write lands only while the unlock input is high. The start-up length and the source selection cannot change while the oscillator is enabled or still reported stable. The frequency-range code and the source selection go straight to the oscillator's analog controls. A pin-override output tells the port logic to release the oscillator pins whenever the oscillator is enabled.

Top module: `xosc_startup_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and osc_run, osc_stable, clk_avail, pin_override, src_ext and freq_range are all 0.
- R2: A write changes the register only in a cycle where unlock is 1; a write with unlock at 0 leaves rd_data unchanged. The layout is bit 7 always-on, bits 5:4 start-up code, bits 3:2 frequency range, bit 1 source select, bit 0 enable, and bit 6 always reads 0.
- R3: The start-up code (bits 5:4) and the source select (bit 1) keep their value on a write made while enable is 1 or osc_stable is 1. The other fields still update on such a write.
- R4: A write of start-up code 3 keeps the previous start-up code. The other fields of the same write still take effect.
- R5: With enable at 1 and always-on at 0, osc_run is 1 one cycle after periph_req or main_req is 1, and 0 one cycle after both are 0.
- R6: With enable at 1 and always-on at 1, osc_run is 1 in sleep modes 0 (active), 1 (idle) and 2 (standby). In mode 3 (power-down) it is 1 only while a request is present.
- R7: osc_stable rises on the clock edge that takes in the Nth osc_tick pulse after osc_run rose. N is 256, 1024 or 4096 for start-up codes 0, 1 and 2. Cycles without a tick do not count.
- R8: When osc_run falls, osc_stable clears on the next edge and the tick count is discarded, so the next start waits the full N ticks again.
- R9: While osc_stable is 1 and a request is present, clk_avail rises on the edge of the second osc_tick. It returns to 0 one cycle after the request is removed.
- R10: freq_range follows bits 3:2 and src_ext follows bit 1 of the register. pin_override is 1 exactly while the enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| unlock | input | 1 | Write permission for this cycle |
| rd_data | output | 8 | Register read value |
| periph_req | input | 1 | Peripheral clock request |
| main_req | input | 1 | Main-clock request |
| sleep_mode | input | 2 | 0 active, 1 idle, 2 standby, 3 power-down |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| osc_run | output | 1 | Oscillator run enable |
| freq_range | output | 2 | Frequency-range code to the oscillator bias |
| src_ext | output | 1 | 1 selects an external clock, 0 a crystal |
| pin_override | output | 1 | Takes the oscillator pins away from port logic |
| osc_stable | output | 1 | Start-up wait complete |
| clk_avail | output | 1 | Requested clock usable |

## Verification
The hardest case to reach is the short window where enable has already been cleared but osc_stable is still 1. The lock must still hold the start-up code in that window. The bench reaches it by bringing the oscillator to stable and then making two unlocked writes on back-to-back cycles: the first clears enable, and the second tries to change the start-up code and source while the stable flag has not yet fallen. A restart test lets start-up finish, drops into power-down, and checks that a fresh start again needs the full tick count.

// File: rtl/xosc_pkg.sv
// Package: shared field layout, sleep-mode codes and helpers for the
// oscillator start-up controller. Assumes an 8-bit control register.
package xosc_pkg;

    localparam logic [1:0] SLP_ACTIVE  = 2'd0;
    localparam logic [1:0] SLP_IDLE    = 2'd1;
    localparam logic [1:0] SLP_STANDBY = 2'd2;
    localparam logic [1:0] SLP_PDOWN   = 2'd3;

    localparam logic [1:0] SUT_RESERVED = 2'd3;

    typedef struct packed {
        logic       always_on;
        logic [1:0] sut_code;
        logic [1:0] frq_code;
        logic       src_ext;
        logic       enable;
    } xosc_cfg_t;

    // Map the configuration fields to their byte positions; bit 6 reads zero.
    function automatic logic [7:0] cfg_to_byte(input xosc_cfg_t c);
        return {c.always_on, 1'b0, c.sut_code, c.frq_code, c.src_ext, c.enable};
    endfunction

    // Extract configuration fields from a written byte; bit 6 is dropped.
    function automatic xosc_cfg_t byte_to_cfg(input logic [7:0] b);
        xosc_cfg_t c;
        c.always_on = b[7];
        c.sut_code  = b[5:4];
        c.frq_code  = b[3:2];
        c.src_ext   = b[1];
        c.enable    = b[0];
        return c;
    endfunction

endpackage

// File: rtl/xosc_cfg_reg.sv
// Module: guarded control register. A write lands only when unlock is
// high. The start-up code and source select are frozen while the
// oscillator is enabled or reported stable, and the reserved start-up
// code is rejected. Assumes wr_en and unlock are synchronous to clk.
module xosc_cfg_reg
    import xosc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       unlock,
    input  logic       stable,
    output xosc_cfg_t  cfg
);

    xosc_cfg_t cfg_q;
    xosc_cfg_t cfg_d;
    xosc_cfg_t wr_cfg;
    logic      locked;
    logic      wr_ok;

    assign wr_cfg = byte_to_cfg(wr_data);
    assign locked = cfg_q.enable | stable;
    assign wr_ok  = wr_en & unlock;

    // Next-state merge: apply permitted fields, hold frozen or reserved ones.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) begin
            cfg_d.always_on = wr_cfg.always_on;
            cfg_d.frq_code  = wr_cfg.frq_code;
            cfg_d.enable    = wr_cfg.enable;
            if (!locked) begin
                cfg_d.src_ext = wr_cfg.src_ext;
                if (wr_cfg.sut_code != SUT_RESERVED) begin
                    cfg_d.sut_code = wr_cfg.sut_code;
                end
            end
        end
    end

    // Register state with synchronous reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/xosc_run_ctl.sv
// Module: run arbiter. Decides from enable, always-on, requests and sleep
// mode whether the oscillator runs, and registers that decision.
// Assumes requests and sleep_mode are synchronous to clk.
module xosc_run_ctl
    import xosc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       always_on,
    input  logic       periph_req,
    input  logic       main_req,
    input  logic [1:0] sleep_mode,
    output logic       osc_run,
    output logic       any_req
);

    logic run_d;
    logic run_q;
    logic mode_keeps;

    assign any_req    = periph_req | main_req;
    assign mode_keeps = always_on & (sleep_mode != SLP_PDOWN);
    assign run_d      = enable & (any_req | mode_keeps);

    // Register the run decision so osc_run is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    assign osc_run = run_q;

endmodule

// File: rtl/xosc_startup_seq.sv
// Module: start-up sequencer. Counts oscillator ticks after osc_run rises
// until the selected length is reached, then raises stable. A ready
// counter then needs READY_TICKS ticks of request before clk_avail.
// Assumes osc_tick is a single-cycle pulse synchronous to clk.
module xosc_startup_seq #(
    parameter int SUT_LOG2_BASE = 8,
    parameter int SUT_LOG2_STEP = 2,
    parameter int READY_TICKS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_run,
    input  logic [1:0] sut_code,
    input  logic       osc_tick,
    input  logic       any_req,
    output logic       stable,
    output logic       clk_avail
);

    localparam int CNT_W = SUT_LOG2_BASE + 2 * SUT_LOG2_STEP + 1;
    localparam int RDY_W = $clog2(READY_TICKS + 1);
    localparam logic [RDY_W-1:0] RDY_LAST = RDY_W'(READY_TICKS - 1);

    logic [CNT_W-1:0] su_cnt;
    logic [CNT_W-1:0] su_last;
    logic             stable_q;
    logic [RDY_W-1:0] rdy_cnt;
    logic             avail_q;

    // Decode the start-up code into the last count value before stable.
    always_comb begin
        su_last = CNT_W'((1 << (SUT_LOG2_BASE + SUT_LOG2_STEP * int'(sut_code))) - 1);
    end

    // Start-up counter and stable flag; both clear whenever the oscillator stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_run) begin
            su_cnt   <= '0;
            stable_q <= 1'b0;
        end else if (osc_tick && !stable_q) begin
            if (su_cnt == su_last) begin
                stable_q <= 1'b1;
            end else begin
                su_cnt <= su_cnt + 1'b1;
            end
        end
    end

    // Ready counter: counts request ticks after start-up, gating clk_avail.
    always_ff @(posedge clk) begin
        if (!rst_n || !stable_q || !any_req) begin
            rdy_cnt <= '0;
            avail_q <= 1'b0;
        end else if (osc_tick && !avail_q) begin
            if (rdy_cnt == RDY_LAST) begin
                avail_q <= 1'b1;
            end else begin
                rdy_cnt <= rdy_cnt + 1'b1;
            end
        end
    end

    assign stable    = stable_q;
    assign clk_avail = avail_q;

endmodule

// File: rtl/xosc_startup_ctrl.sv
// Module: top of the oscillator enable and start-up controller. Joins the
// guarded register, the run arbiter and the start-up sequencer and drives
// the analog control outputs. Assumes everything is synchronous to clk.
module xosc_startup_ctrl
    import xosc_pkg::*;
#(
    parameter int SUT_LOG2_BASE = 8,
    parameter int SUT_LOG2_STEP = 2,
    parameter int READY_TICKS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       unlock,
    output logic [7:0] rd_data,
    input  logic       periph_req,
    input  logic       main_req,
    input  logic [1:0] sleep_mode,
    input  logic       osc_tick,
    output logic       osc_run,
    output logic [1:0] freq_range,
    output logic       src_ext,
    output logic       pin_override,
    output logic       osc_stable,
    output logic       clk_avail
);

    xosc_cfg_t cfg;
    logic      stable;
    logic      any_req;

    xosc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .unlock  (unlock),
        .stable  (stable),
        .cfg     (cfg)
    );

    xosc_run_ctl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg.enable),
        .always_on  (cfg.always_on),
        .periph_req (periph_req),
        .main_req   (main_req),
        .sleep_mode (sleep_mode),
        .osc_run    (osc_run),
        .any_req    (any_req)
    );

    xosc_startup_seq #(
        .SUT_LOG2_BASE (SUT_LOG2_BASE),
        .SUT_LOG2_STEP (SUT_LOG2_STEP),
        .READY_TICKS   (READY_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_run   (osc_run),
        .sut_code  (cfg.sut_code),
        .osc_tick  (osc_tick),
        .any_req   (any_req),
        .stable    (stable),
        .clk_avail (clk_avail)
    );

    assign rd_data      = cfg_to_byte(cfg);
    assign freq_range   = cfg.frq_code;
    assign src_ext      = cfg.src_ext;
    assign pin_override = cfg.enable;
    assign osc_stable   = stable;

endmodule

// File: rtl/xosc_startup_ctrl_chk.sv
// Checker: temporal properties of the start-up controller, seen at its ports.
module xosc_startup_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       unlock,
    input logic [7:0] rd_data,
    input logic       osc_tick,
    input logic       osc_run,
    input logic       osc_stable,
    input logic       clk_avail
);

    AST_WRITE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> $stable(rd_data)); // R2

    AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] == 1'b0); // R2

    AST_SUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] || osc_stable) |=> $stable(rd_data[5:4])); // R3

    AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] || osc_stable) |=> $stable(rd_data[1])); // R3

    AST_NO_RESERVED_SUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] != 2'b11); // R4

    AST_RUN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_run) |-> $past(rd_data[0])); // R5

    AST_STABLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stable) |-> $past(osc_tick)); // R7

    AST_STOP_CLEARS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> !osc_stable); // R8

    AST_AVAIL_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_stable |=> !clk_avail); // R9

endmodule

bind xosc_startup_ctrl xosc_startup_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlock     (unlock),
    .rd_data    (rd_data),
    .osc_tick   (osc_tick),
    .osc_run    (osc_run),
    .osc_stable (osc_stable),
    .clk_avail  (clk_avail)
);

// File: tb/test_xosc_startup_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_xosc_startup_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       unlock = 1'b0;
    logic [7:0] rd_data;
    logic       periph_req = 1'b0;
    logic       main_req = 1'b0;
    logic [1:0] sleep_mode = 2'd0;
    logic       osc_tick = 1'b0;
    logic       osc_run;
    logic [1:0] freq_range;
    logic       src_ext;
    logic       pin_override;
    logic       osc_stable;
    logic       clk_avail;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xosc_startup_ctrl i_xosc_startup_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .unlock       (unlock),
        .rd_data      (rd_data),
        .periph_req   (periph_req),
        .main_req     (main_req),
        .sleep_mode   (sleep_mode),
        .osc_tick     (osc_tick),
        .osc_run      (osc_run),
        .freq_range   (freq_range),
        .src_ext      (src_ext),
        .pin_override (pin_override),
        .osc_stable   (osc_stable),
        .clk_avail    (clk_avail)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic u = 1'b1);
        wr_en = 1'b1; wr_data = d; unlock = u;
        step();
        wr_en = 1'b0; unlock = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; step();
            osc_tick = 1'b0; step();
        end
    endtask

    function automatic int sut_len(input int code);
        return 256 << (2 * code);
    endfunction

    // Bring the oscillator to a stopped, unlocked state with register cleared.
    task automatic quiesce();
        periph_req = 1'b0; main_req = 1'b0; sleep_mode = 2'd0;
        wr(8'h00);
        step(3);
        wr(8'h00);
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 osc_run", osc_run, 0);
        check("R1 osc_stable", osc_stable, 0);
        check("R1 clk_avail", clk_avail, 0);
        check("R1 outputs", {pin_override, src_ext, freq_range}, 0);
    endtask

    task automatic t_unlock();
        wr(8'h0C, 1'b0);
        check("R2 write without unlock", rd_data, 8'h00);
        wr(8'hCC, 1'b1);
        check("R2 unlocked write, bit6 zero", rd_data, 8'h8C);
        quiesce();
    endtask

    task automatic t_outputs();
        wr(8'h0A);
        check("R10 freq_range", freq_range, 2);
        check("R10 src_ext", src_ext, 1);
        check("R10 pin_override off", pin_override, 0);
        wr(8'h0B);
        check("R10 pin_override on", pin_override, 1);
        quiesce();
    endtask

    task automatic t_reserved();
        wr(8'h10);
        check("R4 code 1 stored", rd_data, 8'h10);
        wr(8'h34);
        check("R4 reserved code ignored, frq taken", rd_data, 8'h14);
        quiesce();
    endtask

    task automatic t_on_demand();
        wr(8'h01);
        step(2);
        check("R5 idle without request", osc_run, 0);
        periph_req = 1'b1; step();
        check("R5 runs on periph_req", osc_run, 1);
        periph_req = 1'b0; step();
        check("R5 stops after request", osc_run, 0);
        main_req = 1'b1; step();
        check("R5 runs on main_req", osc_run, 1);
        main_req = 1'b0; step();
        check("R5 stops after main_req", osc_run, 0);
        quiesce();
    endtask

    task automatic t_always_on();
        wr(8'h81);
        sleep_mode = 2'd1; step(2);
        check("R6 idle runs", osc_run, 1);
        sleep_mode = 2'd2; step();
        check("R6 standby runs", osc_run, 1);
        sleep_mode = 2'd3; step();
        check("R6 power-down stops", osc_run, 0);
        main_req = 1'b1; step();
        check("R6 power-down with request", osc_run, 1);
        quiesce();
    endtask

    task automatic t_startup(input int code);
        wr(8'h80 | 8'(code << 4) | 8'h01);
        step();
        check("R7 running", osc_run, 1);
        step(5);
        check("R7 no ticks no stable", osc_stable, 0);
        ticks(sut_len(code) - 1);
        check($sformatf("R7 code %0d one tick short", code), osc_stable, 0);
        ticks(1);
        check($sformatf("R7 code %0d stable", code), osc_stable, 1);
    endtask

    task automatic t_restart();
        sleep_mode = 2'd3; step(2);
        check("R8 stopped", osc_run, 0);
        check("R8 stable cleared", osc_stable, 0);
        sleep_mode = 2'd0; step();
        ticks(255);
        check("R8 full wait again", osc_stable, 0);
        ticks(1);
        check("R8 stable after restart", osc_stable, 1);
    endtask

    task automatic t_ready();
        ticks(3);
        check("R9 no request no avail", clk_avail, 0);
        periph_req = 1'b1;
        ticks(1);
        check("R9 one tick not avail", clk_avail, 0);
        ticks(1);
        check("R9 avail after two ticks", clk_avail, 1);
        periph_req = 1'b0; step();
        check("R9 avail drops", clk_avail, 0);
        check("R9 still stable", osc_stable, 1);
    endtask

    // Stable and enable cleared: lock must hold until stable falls.
    task automatic t_lock();
        wr(8'h21);
        check("R3 locked while enabled", rd_data, 8'h01);
        wr(8'h00);
        check("R3 enable cleared", rd_data[0], 0);
        check("R3 stable lingers", osc_stable, 1);
        wr(8'h2E);
        check("R3 locked while stable, frq taken", rd_data, 8'h0C);
        step(2);
        check("R3 stable fell", osc_stable, 0);
        wr(8'h22);
        check("R3 unlocked after stop", rd_data, 8'h22);
        quiesce();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_unlock();
        t_outputs();
        t_reserved();
        t_on_demand();
        t_always_on();
        t_startup(0);
        t_restart();
        t_ready();
        t_lock();
        t_startup(1);
        quiesce();
        t_startup(2);
        quiesce();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule